// File: doc/BRIEF.md
# Reset Source Controller with Clock-Loss Detection

This block merges the reset requests of a small chip into a single system reset and keeps a record of what caused the most recent one. It watches three sources. The first is an active-low external reset pin. The second is a missing-clock detector. The third is the output of a supply-monitor comparator, where a high level means the supply is above its threshold.

The detector runs from a free-running reference clock. It samples the system clock level through a synchronizer. It reloads a countdown on every edge it sees, and it flags a clock loss when the system clock sits at one level for longer than the timeout.

All of the logic sits in the reference-clock domain, and a power-on reset clears it. The system reset is held for a fixed number of reference cycles after the last source goes quiet, and it then deasserts synchronously. Software uses a two-entry register interface. Through it, software reads the cause flags, enables the detector, enables the supply monitor, arms the monitor as a reset source and reads the supply status.

Top module: `reset_hub`

## Requirements
- R1: A low level on `ext_rst_n` drives `sys_rst_n` low at the third rising `ref_clk` edge after the pin falls (two synchronizer stages plus one register). `sys_rst_n` stays low while the pin is low.
- R2: `sys_rst_n` is still low after the ninth rising `ref_clk` edge following the last source going quiet. It is high after the tenth edge (two synchronizer stages plus a hold of 8 cycles).
- R3: After a reset caused only by the pin, register 0 (`reg_sel`=0) reads 0x01. Bit 0 is the pin flag, bit 1 is the supply flag, bit 2 is the clock-loss flag, and bits 7:3 read 0.
- R4: With the detector enabled, a system clock stuck low or stuck high for longer than the timeout (16 reference cycles) asserts `sys_rst_n` low. When the clock returns and the hold expires, register 0 reads 0x04.
- R5: Writing register 0 with bit 2 = 0 disables the detector. A stopped system clock then causes no reset, and the flags do not change.
- R6: A system clock that keeps toggling with a half period well below the timeout never causes a reset.
- R7: A reset from any cause other than clock loss leaves bit 2 of register 0 at 0, even when the previous reset was a clock loss.
- R8: Register 1 reads {enable, status, 6'b0}. Bit 7 is the monitor enable, which is read/write. Bit 6 is the synchronized supply status, which is read-only (1 = above threshold). Bits 5:0 always read 0.
- R9: A low supply resets the system only when the monitor is enabled (register 1 bit 7) and also armed (a write to register 0 with bit 1 = 1). After such a reset, register 0 reads 0x02.
- R10: When several sources are active during one reset, each of their flags is set when it ends. Flags of sources that were not active are cleared.
- R11: While `por_n` is low, `sys_rst_n` is low, all flags and enables are 0, and the monitor is not armed. `sys_rst_n` rises at the eighth rising edge after `por_n` is released.
- R12: The detector enable, the monitor enable and the monitor arm survive a system reset, and only `por_n` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; the block's only clock |
| por_n | input | 1 | Asynchronous active-low power-on reset for the block |
| sys_clk | input | 1 | Monitored system clock, sampled as data |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| sup_above | input | 1 | Supply comparator output, 1 = supply above threshold, asynchronous |
| reg_we | input | 1 | Register write strobe, sampled on `ref_clk` |
| reg_sel | input | 1 | Register select: 0 = source flags / controls, 1 = supply-monitor control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| sys_rst_n | output | 1 | Stretched active-low system reset, registered |

## Verification
The checks assume that `sys_clk` toggles with a half period several reference cycles long whenever it runs, so that the detector sees every edge. They also assume that the asynchronous pin and comparator inputs hold each level for many reference cycles, so the synchronizers never miss a pulse. The stimulus keeps to this. It drives `sys_clk` with a 20 ns half period against an 8 ns reference. It starts and stops `sys_clk` only at a chosen level. It holds each source for at least 30 reference cycles, and it leaves each source quiet for 40 cycles before the flags are read. Register writes are issued only while the system reset is released.

// File: rtl/rh_pkg.sv
`timescale 1ns/1ps
package rh_pkg;
   localparam int NUM_SRC   = 3;
   localparam int SRC_PIN   = 0;
   localparam int SRC_SUP   = 1;
   localparam int SRC_LOSS  = 2;
   localparam int REG_W     = 8;
   localparam int MON_EN_B  = 7;
   localparam int MON_ST_B  = 6;
   typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rh_sync.sv
`timescale 1ns/1ps
module rh_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rh_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rh_clk_mon.sv
`timescale 1ns/1ps
module rh_clk_mon #(
   parameter int TIMEOUT     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic enable,
   input  logic mon_clk,
   output logic lost
);
   localparam int CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT);

   logic lvl_s, lvl_d, edge_seen;
   logic [CW-1:0] cnt;

   rh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lvl_sync (
      .clk(ref_clk), .rst_n(rst_n), .d(mon_clk), .q(lvl_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl_s;
   end

   assign edge_seen = lvl_s ^ lvl_d;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= RELOAD;
         lost <= 1'b0;
      end else begin
         if (!enable || edge_seen)  cnt <= RELOAD;
         else if (cnt != '0)        cnt <= cnt - 1'b1;
         lost <= enable && !edge_seen && (cnt == '0);
      end
   end
endmodule

// File: rtl/rh_rst_seq.sv
`timescale 1ns/1ps
module rh_rst_seq
   import rh_pkg::*;
#(
   parameter int HOLD = 8
) (
   input  logic     ref_clk,
   input  logic     rst_n,
   input  src_vec_t src,
   output logic     sys_rst_n,
   output src_vec_t flags
);
   localparam int HW = $clog2(HOLD + 1);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

   logic          in_rst;
   logic [HW-1:0] hold_cnt;
   src_vec_t      acc;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         in_rst   <= 1'b1;
         hold_cnt <= HOLD_V;
         acc      <= '0;
         flags    <= '0;
      end else if (|src) begin
         in_rst   <= 1'b1;
         hold_cnt <= HOLD_V;
         acc      <= acc | src;
      end else if (in_rst) begin
         if (hold_cnt <= HW'(1)) begin
            in_rst <= 1'b0;
            flags  <= acc;
            acc    <= '0;
         end else begin
            hold_cnt <= hold_cnt - 1'b1;
         end
      end
   end

   assign sys_rst_n = ~in_rst;
endmodule

// File: rtl/reset_hub.sv
`timescale 1ns/1ps
module reset_hub
   import rh_pkg::*;
#(
   parameter int TIMEOUT     = 16,
   parameter int HOLD        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             ref_clk,
   input  logic             por_n,
   input  logic             sys_clk,
   input  logic             ext_rst_n,
   input  logic             sup_above,
   input  logic             reg_we,
   input  logic             reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sys_rst_n
);
   generate
      if (TIMEOUT < 2) begin : g_chk_to
         $error("reset_hub: TIMEOUT must be at least 2");
      end
      if (HOLD < 1) begin : g_chk_hold
         $error("reset_hub: HOLD must be at least 1");
      end
   endgenerate

   logic     pin_s, sup_s, pin_low, clk_loss, sup_trip;
   logic     mcd_en, mon_en, sup_sel;
   src_vec_t src, flags;

   rh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk(ref_clk), .rst_n(por_n), .d(ext_rst_n), .q(pin_s)
   );
   rh_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sup_sync (
      .clk(ref_clk), .rst_n(por_n), .d(sup_above), .q(sup_s)
   );

   rh_clk_mon #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
      .ref_clk(ref_clk), .rst_n(por_n), .enable(mcd_en),
      .mon_clk(sys_clk), .lost(clk_loss)
   );

   assign pin_low  = ~pin_s;
   assign sup_trip = mon_en & sup_sel & ~sup_s;

   always_comb begin
      src           = '0;
      src[SRC_PIN]  = pin_low;
      src[SRC_SUP]  = sup_trip;
      src[SRC_LOSS] = clk_loss;
   end

   rh_rst_seq #(.HOLD(HOLD)) u_seq (
      .ref_clk(ref_clk), .rst_n(por_n), .src(src),
      .sys_rst_n(sys_rst_n), .flags(flags)
   );

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n) begin
         mcd_en  <= 1'b0;
         sup_sel <= 1'b0;
         mon_en  <= 1'b0;
      end else if (reg_we) begin
         if (!reg_sel) begin
            mcd_en  <= reg_wdata[SRC_LOSS];
            sup_sel <= reg_wdata[SRC_SUP];
         end else begin
            mon_en  <= reg_wdata[MON_EN_B];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (!reg_sel) begin
         reg_rdata[NUM_SRC-1:0] = flags;
      end else begin
         reg_rdata[MON_EN_B] = mon_en;
         reg_rdata[MON_ST_B] = sup_s;
      end
   end
endmodule

// File: rtl/reset_hub_chk.sv
`timescale 1ns/1ps
module reset_hub_chk
   import rh_pkg::*;
#(
   parameter int HOLD = 8
) (
   input logic             ref_clk,
   input logic             por_n,
   input logic             sys_rst_n,
   input logic             pin_low,
   input logic             clk_loss,
   input logic             sup_trip,
   input logic             mcd_en,
   input logic             mon_en,
   input logic             sup_sel,
   input logic             reg_sel,
   input logic [REG_W-1:0] reg_rdata,
   input src_vec_t         flags
);
   localparam int QW = $clog2(HOLD + 2);
   logic [QW-1:0] quiet;
   logic          any_src;

   assign any_src = pin_low | clk_loss | sup_trip;

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n)                   quiet <= '0;
      else if (any_src)             quiet <= '0;
      else if (quiet != QW'(HOLD+1)) quiet <= quiet + 1'b1;
   end

   a_r1_pin_forces_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
      pin_low |=> !sys_rst_n);

   a_r2_release_after_hold: assert property (@(posedge ref_clk) disable iff (!por_n)
      $rose(sys_rst_n) |-> quiet == QW'(HOLD));

   a_r4_loss_forces_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
      clk_loss |=> !sys_rst_n);

   a_r5_disabled_no_loss: assert property (@(posedge ref_clk) disable iff (!por_n)
      $past(!mcd_en) |-> !clk_loss);

   a_r9_supply_needs_both: assert property (@(posedge ref_clk) disable iff (!por_n)
      sup_trip |-> (mon_en && sup_sel));

   a_r9_supply_forces_reset: assert property (@(posedge ref_clk) disable iff (!por_n)
      sup_trip |=> !sys_rst_n);

   a_r8_low_bits_zero: assert property (@(posedge ref_clk) disable iff (!por_n)
      reg_sel |-> reg_rdata[5:0] == 6'd0);

   a_r10_flags_move_on_release: assert property (@(posedge ref_clk) disable iff (!por_n)
      !$stable(flags) |-> $rose(sys_rst_n));
endmodule

bind reset_hub reset_hub_chk #(.HOLD(HOLD)) u_chk (
   .ref_clk(ref_clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
   .pin_low(pin_low), .clk_loss(clk_loss), .sup_trip(sup_trip),
   .mcd_en(mcd_en), .mon_en(mon_en), .sup_sel(sup_sel),
   .reg_sel(reg_sel), .reg_rdata(reg_rdata), .flags(flags)
);

// File: tb/reset_hub_tb_top.sv
`timescale 1ns/1ps
module reset_hub_tb_top;
   logic       ref_clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_clk = 1'b0;
   logic       clk_run = 1'b1;
   logic       ext_rst_n = 1'b1;
   logic       sup_above = 1'b1;
   logic       reg_we = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sys_rst_n;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 ref_clk = ~ref_clk;
   always begin
      #20;
      if (clk_run) sys_clk = ~sys_clk;
   end

   reset_hub dut_i (
      .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk),
      .ext_rst_n(ext_rst_n), .sup_above(sup_above),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge ref_clk);
      @(negedge ref_clk);
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
      tick(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic stop_clk(input logic lvl);
      wait (sys_clk == lvl);
      clk_run = 1'b0;
      @(negedge ref_clk);
   endtask

   function automatic logic [7:0] exp_flags(input logic [2:0] mask, input logic men,
                                            input logic sel, input logic den);
      return {5'b0, mask[2] & den, mask[1] & men & sel, mask[0]};
   endfunction

   function automatic logic [7:0] exp_ctrl(input logic men, input logic st);
      return {men, st, 6'b0};
   endfunction

   initial begin
      repeat (200000) @(posedge ref_clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, prev;
      void'($urandom(32'h5eed_1234));
      // R11 power-on state
      tick(3);
      chk("R11 reset low during por", {7'b0, sys_rst_n}, 8'h00);
      rd(1'b0, r); chk("R11 flags clear", r, 8'h00);
      rd(1'b1, r); chk("R11 enables clear", r, exp_ctrl(1'b0, 1'b1));
      por_n = 1'b1;
      tick(7); chk("R11 held 7 edges", {7'b0, sys_rst_n}, 8'h00);
      tick(1); chk("R11 released at 8th edge", {7'b0, sys_rst_n}, 8'h01);

      // R1 / R2 / R3 pin reset timing and flag
      ext_rst_n = 1'b0;
      tick(2); chk("R1 not yet at edge 2", {7'b0, sys_rst_n}, 8'h01);
      tick(1); chk("R1 low at edge 3", {7'b0, sys_rst_n}, 8'h00);
      tick(20); chk("R1 held while pin low", {7'b0, sys_rst_n}, 8'h00);
      ext_rst_n = 1'b1;
      tick(9); chk("R2 still low at edge 9", {7'b0, sys_rst_n}, 8'h00);
      tick(1); chk("R2 high at edge 10", {7'b0, sys_rst_n}, 8'h01);
      rd(1'b0, r); chk("R3 pin flag", r, 8'h01);

      // R8 / R9 supply monitor
      wr(1'b1, 8'hFF);
      rd(1'b1, r); chk("R8 ctrl readback", r, exp_ctrl(1'b1, 1'b1));
      sup_above = 1'b0; tick(40);
      rd(1'b1, r); chk("R8 status low", r, exp_ctrl(1'b1, 1'b0));
      chk("R9 enabled not armed no reset", {7'b0, sys_rst_n}, 8'h01);
      wr(1'b1, 8'h00); wr(1'b0, 8'h02); tick(40);
      chk("R9 armed not enabled no reset", {7'b0, sys_rst_n}, 8'h01);
      rd(1'b0, r); chk("R9 flags untouched", r, 8'h01);
      wr(1'b1, 8'h80); tick(5);
      chk("R9 enabled and armed resets", {7'b0, sys_rst_n}, 8'h00);
      sup_above = 1'b1; tick(40);
      chk("R9 released", {7'b0, sys_rst_n}, 8'h01);
      rd(1'b0, r); chk("R9 supply flag", r, 8'h02);
      rd(1'b1, r); chk("R8 status high", r, exp_ctrl(1'b1, 1'b1));
      wr(1'b0, 8'h00);

      // R5 detector disabled
      stop_clk(1'b0); tick(80);
      chk("R5 disabled stopped clock no reset", {7'b0, sys_rst_n}, 8'h01);
      rd(1'b0, r); chk("R5 flags untouched", r, 8'h02);
      clk_run = 1'b1; tick(10);

      // R6 running clock with detector on
      wr(1'b0, 8'h04);
      tick(300); chk("R6 running clock no reset", {7'b0, sys_rst_n}, 8'h01);

      // R4 stuck low and stuck high
      stop_clk(1'b0); tick(40);
      chk("R4 stuck low resets", {7'b0, sys_rst_n}, 8'h00);
      clk_run = 1'b1; tick(40);
      chk("R4 recovers", {7'b0, sys_rst_n}, 8'h01);
      rd(1'b0, r); chk("R4 loss flag", r, 8'h04);
      stop_clk(1'b1); tick(40);
      chk("R4 stuck high resets", {7'b0, sys_rst_n}, 8'h00);
      clk_run = 1'b1; tick(40);
      rd(1'b0, r); chk("R4 loss flag high case", r, 8'h04);

      // R7 pin after loss; R12 enables survive
      ext_rst_n = 1'b0; tick(30); ext_rst_n = 1'b1; tick(40);
      rd(1'b0, r); chk("R7 loss flag cleared", r, 8'h01);
      rd(1'b1, r); chk("R12 monitor enable kept", r, exp_ctrl(1'b1, 1'b1));
      stop_clk(1'b0); tick(40);
      chk("R12 detector still enabled", {7'b0, sys_rst_n}, 8'h00);
      clk_run = 1'b1; tick(40);

      // R10 simultaneous sources
      ext_rst_n = 1'b0; stop_clk(1'b1); tick(40);
      ext_rst_n = 1'b1; clk_run = 1'b1; tick(40);
      rd(1'b0, r); chk("R10 pin and loss flags", r, 8'h05);

      // random mix
      rd(1'b0, prev);
      for (int it = 0; it < 24; it++) begin
         logic men, sel, den;
         logic [2:0] mask;
         logic [7:0] ef;
         int dur;
         men = 1'($urandom % 2); sel = 1'($urandom % 2); den = 1'($urandom % 2);
         mask = 3'($urandom % 8); if (mask == 3'b0) mask = 3'b001;
         dur = 30 + int'($urandom % 30);
         wr(1'b1, {men, 7'b0});
         wr(1'b0, {5'b0, den, sel, 1'b0});
         if (mask[2]) stop_clk(1'($urandom % 2));
         if (mask[0]) ext_rst_n = 1'b0;
         if (mask[1]) sup_above = 1'b0;
         tick(dur);
         ef = exp_flags(mask, men, sel, den);
         chk("R10 random mid-episode reset", {7'b0, sys_rst_n}, {7'b0, ef == 8'h00});
         ext_rst_n = 1'b1; sup_above = 1'b1; clk_run = 1'b1;
         tick(40);
         chk("R2 random released", {7'b0, sys_rst_n}, 8'h01);
         if (ef != 8'h00) prev = ef;
         rd(1'b0, r); chk("R10 random flags", r, prev);
         rd(1'b1, r); chk("R8 random ctrl", r, exp_ctrl(men, 1'b1));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule